// File: doc/BRIEF.md
# Indexed Configuration Registers with A20 Gate

This block gives the CPU access to a small bank of configuration registers through two I/O ports: one port holds a register number and the other reads or writes the register that number selects. The bank has three slots. The first holds a fixed version code. The second holds speed and ready-handling controls. The third holds option enables. Every writable field also drives a dedicated output, so timing logic elsewhere can use the setting directly.

The same block produces the address-bit-20 gate. The gate is the OR of three terms: a request from the keyboard controller, a control bit held in a system control port, and a flag that is high while DMA or a bus master owns the bus. A write to the system control port reaches the gate on the first clock after the write cycle. Another block applies the gate to the address.

Top module: `idx_cfg_a20`

## Requirements
- R1: After reset the index register reads 00h. The speed slot reads 60h, which gives `cop_rdy_sel_o`=1, `af_delay_o`=1 and `clk_code_o`=0. The option slot and the system control port read 00h. With both `kbc_a20_i` and `nc_master_i` low, `a20_gate_o` is 0.
- R2: A write to I/O address 0022h loads the index register. A read of 0022h returns the index.
- R3: Index 8Dh selects the version slot. Reading data port 0023h returns the `VERSION` parameter, and writes to it have no effect.
- R4: Index 8Eh selects the speed slot. Its writable fields are:
  - bits 1:0, a clock code, driven on `clk_code_o`;
  - bit 5, the coprocessor ready source, driven on `cop_rdy_sel_o` (1 means the coprocessor supplies ready);
  - bit 6, the delayed local-access sampling with one extra wait state, driven on `af_delay_o`.

  All other bits of this slot ignore writes and read 0.
- R5: Index 8Fh selects the option slot. Its fields are:
  - bit 0, the fast matched-memory timing, driven on `mm_fast_o`;
  - bit 1, the matched-memory enable, driven on `mm_en_o`;
  - bit 2, the fast video cycle enable, driven on `fast_vid_o`;
  - bit 3, the read data-ready extend, driven on `rdy_extend_o`.

  Bits 7:4 ignore writes and read 0.
- R6: When the index is outside 8Dh to 8Fh, a data-port write changes no register and a data-port read returns FFh.
- R7: In the system control port at 0092h only bit 1 is writable. All other bits read 0.
- R8: `a20_gate_o` equals `kbc_a20_i` OR bit 1 of port 0092h OR `nc_master_i`.
- R9: A write to 0092h takes effect at the clock edge that ends the write cycle, and `a20_gate_o` follows from that edge.
- R10: `io_rdata_o` is 00h whenever `io_rd_i` is low or the address is none of the three ports.
- R11: The index register keeps its value across any number of data-port reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | I/O write, one cycle per access |
| io_rd_i | input | 1 | I/O read |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data; combinational while `io_rd_i` is high |
| kbc_a20_i | input | 1 | A20 request from the keyboard controller |
| nc_master_i | input | 1 | DMA or a bus master owns the bus |
| a20_gate_o | output | 1 | Address-bit-20 gate |
| clk_code_o | output | 2 | Clock code field of the speed slot |
| cop_rdy_sel_o | output | 1 | Coprocessor ready source select |
| af_delay_o | output | 1 | Delayed local-access sampling enable |
| mm_fast_o | output | 1 | Fast matched-memory timing |
| mm_en_o | output | 1 | Matched-memory enable |
| fast_vid_o | output | 1 | Fast video cycle enable |
| rdy_extend_o | output | 1 | Read data-ready extend |

## Verification
Each configuration bit drives a port directly. A corrupted slot therefore shows on the dedicated outputs on the clock after the faulty write, before any read-back. A wrong index shows up as FFh, or as another slot's data, on the next data-port read. A misdecoded write is caught when the bench reads back the slot it expected to stay unchanged. A fault in the port 0092h bit or in the gate OR shows on `a20_gate_o` one sample after the write edge, so the bench checks the gate on both sides of that edge.

// File: rtl/idx_cfg_pkg.sv
package idx_cfg_pkg;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned BANK_N    = 3;
  localparam logic [7:0]  BANK_BASE = 8'h8D;

  localparam int unsigned SLOT_VER = 0;
  localparam int unsigned SLOT_SPD = 1;
  localparam int unsigned SLOT_OPT = 2;

  // speed slot fields
  localparam int unsigned SPD_COP_RDY = 5;
  localparam int unsigned SPD_AF_DLY  = 6;
  // option slot fields
  localparam int unsigned OPT_MM_FAST = 0;
  localparam int unsigned OPT_MM_EN   = 1;
  localparam int unsigned OPT_FST_VID = 2;
  localparam int unsigned OPT_RDY_EXT = 3;
  // system control port
  localparam int unsigned P92_A20     = 1;

  typedef struct packed {
    logic       rdy_extend;
    logic       fast_vid;
    logic       mm_en;
    logic       mm_fast;
    logic       af_delay;
    logic       cop_rdy;
    logic [1:0] clk_code;
  } cfg_t;

  function automatic logic [DATA_W-1:0] slot_wmask(input int unsigned s);
    case (s)
      SLOT_SPD: slot_wmask = 8'h63;
      SLOT_OPT: slot_wmask = 8'h0F;
      default:  slot_wmask = 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_rstval(input int unsigned s);
    case (s)
      SLOT_SPD: slot_rstval = 8'h60;
      default:  slot_rstval = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/idx_cfg_decode.sv
module idx_cfg_decode #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter logic [ADDR_W-1:0] SYS_PORT = 'h92
) (
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              sys_wr_o,
  output logic              idx_rd_o,
  output logic              dat_rd_o,
  output logic              sys_rd_o
);

  logic idx_hit, dat_hit, sys_hit;

  assign idx_hit = (io_addr_i == IDX_PORT);
  assign dat_hit = (io_addr_i == DAT_PORT);
  assign sys_hit = (io_addr_i == SYS_PORT);

  assign idx_wr_o = io_wr_i & idx_hit;
  assign dat_wr_o = io_wr_i & dat_hit;
  assign sys_wr_o = io_wr_i & sys_hit;
  assign idx_rd_o = io_rd_i & idx_hit;
  assign dat_rd_o = io_rd_i & dat_hit;
  assign sys_rd_o = io_rd_i & sys_hit;

endmodule

// File: rtl/idx_cfg_bank.sv
module idx_cfg_bank
  import idx_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION = 8'h21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] idx_o,
  output logic              slot_hit_o,
  output logic [DATA_W-1:0] slot_rdata_o,
  output cfg_t              cfg_o
);

  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] slot_q [BANK_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_wr_i) idx_q <= wdata_i;
  end

  // wrapping subtract: indexes below the base land far above BANK_N
  assign offset     = idx_q - BANK_BASE;
  assign slot_hit_o = (offset < DATA_W'(BANK_N));

  for (genvar g = 0; g < BANK_N; g++) begin : g_slot
    localparam logic [DATA_W-1:0] WM = slot_wmask(g);
    localparam logic [DATA_W-1:0] RV = slot_rstval(g) & WM;
    if (WM == '0) begin : g_ro
      assign slot_q[g] = (g == SLOT_VER) ? VERSION : '0;
    end else begin : g_rw
      logic sel;
      assign sel = dat_wr_i & slot_hit_o & (offset == DATA_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  slot_q[g] <= RV;
        else if (sel) slot_q[g] <= wdata_i & WM;
      end
    end
  end

  always_comb begin
    slot_rdata_o = '1;
    for (int k = 0; k < BANK_N; k++)
      if (offset == DATA_W'(k)) slot_rdata_o = slot_q[k];
  end

  assign idx_o = idx_q;

  assign cfg_o.clk_code   = slot_q[SLOT_SPD][1:0];
  assign cfg_o.cop_rdy    = slot_q[SLOT_SPD][SPD_COP_RDY];
  assign cfg_o.af_delay   = slot_q[SLOT_SPD][SPD_AF_DLY];
  assign cfg_o.mm_fast    = slot_q[SLOT_OPT][OPT_MM_FAST];
  assign cfg_o.mm_en      = slot_q[SLOT_OPT][OPT_MM_EN];
  assign cfg_o.fast_vid   = slot_q[SLOT_OPT][OPT_FST_VID];
  assign cfg_o.rdy_extend = slot_q[SLOT_OPT][OPT_RDY_EXT];

  // R2, R11: index moves only on an index-port write
  a_r11_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr_i |=> $stable(idx_o));

  // R6: no bank write without a mapped index
  a_r6_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dat_wr_i || !slot_hit_o) |=> $stable(cfg_o));

  // R3: version slot always reads the parameter
  a_r3_version_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_o == BANK_BASE) |-> (slot_hit_o && slot_rdata_o == VERSION));

endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
  import idx_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_wr_i,
  input  logic              a20_bit_i,
  input  logic              kbc_a20_i,
  input  logic              nc_master_i,
  output logic [DATA_W-1:0] sys_rdata_o,
  output logic              a20_o
);

  logic a20_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       a20_q <= 1'b0;
    else if (sys_wr_i) a20_q <= a20_bit_i;
  end

  always_comb begin
    sys_rdata_o          = '0;
    sys_rdata_o[P92_A20] = a20_q;
  end

  // non-CPU bus owners always see the full address
  assign a20_o = kbc_a20_i | a20_q | nc_master_i;

endmodule

// File: rtl/idx_cfg_a20.sv
module idx_cfg_a20
  import idx_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter logic [ADDR_W-1:0] SYS_PORT = 'h92,
  parameter logic [7:0]        VERSION  = 8'h21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic              kbc_a20_i,
  input  logic              nc_master_i,
  output logic              a20_gate_o,
  output logic [1:0]        clk_code_o,
  output logic              cop_rdy_sel_o,
  output logic              af_delay_o,
  output logic              mm_fast_o,
  output logic              mm_en_o,
  output logic              fast_vid_o,
  output logic              rdy_extend_o
);

  logic              idx_wr, dat_wr, sys_wr, idx_rd, dat_rd, sys_rd;
  logic [DATA_W-1:0] idx, slot_rdata, sys_rdata;
  logic              slot_hit;
  cfg_t              cfg;

  idx_cfg_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_PORT(IDX_PORT),
    .DAT_PORT(DAT_PORT),
    .SYS_PORT(SYS_PORT)
  ) i_decode (
    .io_addr_i(io_addr_i),
    .io_wr_i  (io_wr_i),
    .io_rd_i  (io_rd_i),
    .idx_wr_o (idx_wr),
    .dat_wr_o (dat_wr),
    .sys_wr_o (sys_wr),
    .idx_rd_o (idx_rd),
    .dat_rd_o (dat_rd),
    .sys_rd_o (sys_rd)
  );

  idx_cfg_bank #(.VERSION(VERSION)) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_wr_i    (idx_wr),
    .dat_wr_i    (dat_wr),
    .wdata_i     (io_wdata_i),
    .idx_o       (idx),
    .slot_hit_o  (slot_hit),
    .slot_rdata_o(slot_rdata),
    .cfg_o       (cfg)
  );

  a20_gate_ctrl i_a20 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_wr_i   (sys_wr),
    .a20_bit_i  (io_wdata_i[P92_A20]),
    .kbc_a20_i  (kbc_a20_i),
    .nc_master_i(nc_master_i),
    .sys_rdata_o(sys_rdata),
    .a20_o      (a20_gate_o)
  );

  always_comb begin
    io_rdata_o = '0;
    if (idx_rd)      io_rdata_o = idx;
    else if (dat_rd) io_rdata_o = slot_rdata;
    else if (sys_rd) io_rdata_o = sys_rdata;
  end

  assign clk_code_o    = cfg.clk_code;
  assign cop_rdy_sel_o = cfg.cop_rdy;
  assign af_delay_o    = cfg.af_delay;
  assign mm_fast_o     = cfg.mm_fast;
  assign mm_en_o       = cfg.mm_en;
  assign fast_vid_o    = cfg.fast_vid;
  assign rdy_extend_o  = cfg.rdy_extend;

  a_r8_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nc_master_i || kbc_a20_i) |-> a20_gate_o);

  a_r9_a20_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == SYS_PORT) |=>
      (a20_gate_o == ($past(io_wdata_i[P92_A20]) || kbc_a20_i || nc_master_i)));

  a_r6_miss_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == DAT_PORT && (idx < BANK_BASE || idx > BANK_BASE + 8'(BANK_N - 1)))
      |-> (io_rdata_o == 8'hFF));

  a_r7_sys_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == SYS_PORT) |-> ((io_rdata_o & 8'hFD) == 8'h00));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || (io_addr_i != IDX_PORT && io_addr_i != DAT_PORT && io_addr_i != SYS_PORT))
      |-> (io_rdata_o == 8'h00));

endmodule

// File: tb/test_idx_cfg_a20.sv
module test_idx_cfg_a20;

  localparam int         CLK_PERIOD  = 10;
  localparam int         WD_CYCLES   = 20000;
  localparam logic [7:0] EXP_VERSION = 8'h21;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0022, 8'h00, 8'h00,        4'd1},  // R1 index reset
    '{1'b0, 16'h0023, 8'h00, 8'hFF,        4'd6},  // R6 index 00 unmapped
    '{1'b1, 16'h0022, 8'h8E, 8'h00,        4'd2},
    '{1'b0, 16'h0022, 8'h00, 8'h8E,        4'd2},  // R2 read index
    '{1'b0, 16'h0023, 8'h00, 8'h60,        4'd1},  // R1 speed default
    '{1'b1, 16'h0023, 8'hFF, 8'h00,        4'd4},
    '{1'b0, 16'h0023, 8'h00, 8'h63,        4'd4},  // R4 mask
    '{1'b1, 16'h0023, 8'h00, 8'h00,        4'd4},
    '{1'b0, 16'h0023, 8'h00, 8'h00,        4'd4},
    '{1'b0, 16'h0022, 8'h00, 8'h8E,        4'd11}, // R11 index kept
    '{1'b1, 16'h0022, 8'h8F, 8'h00,        4'd2},
    '{1'b0, 16'h0023, 8'h00, 8'h00,        4'd1},  // R1 option default
    '{1'b1, 16'h0023, 8'hFF, 8'h00,        4'd5},
    '{1'b0, 16'h0023, 8'h00, 8'h0F,        4'd5},  // R5 mask
    '{1'b1, 16'h0023, 8'hA5, 8'h00,        4'd5},
    '{1'b0, 16'h0023, 8'h00, 8'h05,        4'd5},
    '{1'b1, 16'h0022, 8'h8D, 8'h00,        4'd2},
    '{1'b0, 16'h0023, 8'h00, EXP_VERSION,  4'd3},  // R3 version
    '{1'b1, 16'h0023, 8'h00, 8'h00,        4'd3},
    '{1'b0, 16'h0023, 8'h00, EXP_VERSION,  4'd3},  // R3 write ignored
    '{1'b1, 16'h0022, 8'h90, 8'h00,        4'd2},
    '{1'b1, 16'h0023, 8'hFF, 8'h00,        4'd6},
    '{1'b0, 16'h0023, 8'h00, 8'hFF,        4'd6},  // R6 read ones
    '{1'b1, 16'h0022, 8'h8E, 8'h00,        4'd2},
    '{1'b0, 16'h0023, 8'h00, 8'h00,        4'd6},  // R6 speed untouched
    '{1'b1, 16'h0022, 8'h8F, 8'h00,        4'd2},
    '{1'b0, 16'h0023, 8'h00, 8'h05,        4'd6},  // R6 option untouched
    '{1'b0, 16'h0092, 8'h00, 8'h00,        4'd1},  // R1 port 92 reset
    '{1'b1, 16'h0092, 8'hFF, 8'h00,        4'd7},
    '{1'b0, 16'h0092, 8'h00, 8'h02,        4'd7},  // R7 only bit 1
    '{1'b1, 16'h0092, 8'h00, 8'h00,        4'd7},
    '{1'b0, 16'h0092, 8'h00, 8'h00,        4'd7},
    '{1'b0, 16'h0024, 8'h00, 8'h00,        4'd10}  // R10 other address
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        kbc = 1'b0, ncm = 1'b0;
  logic        a20;
  logic [1:0]  clk_code;
  logic        cop_rdy, af_dly, mm_fast, mm_en, fast_vid, rdy_ext;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_cfg_a20 #(.VERSION(EXP_VERSION)) i_idx_cfg_a20 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .io_addr_i    (addr),
    .io_wr_i      (wr),
    .io_rd_i      (rd),
    .io_wdata_i   (wdata),
    .io_rdata_o   (rdata),
    .kbc_a20_i    (kbc),
    .nc_master_i  (ncm),
    .a20_gate_o   (a20),
    .clk_code_o   (clk_code),
    .cop_rdy_sel_o(cop_rdy),
    .af_delay_o   (af_dly),
    .mm_fast_o    (mm_fast),
    .mm_en_o      (mm_en),
    .fast_vid_o   (fast_vid),
    .rdy_extend_o (rdy_ext)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #(CLK_PERIOD/4);
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [7:0] cfg_bits();
    return {rdy_ext, fast_vid, mm_en, mm_fast, af_dly, cop_rdy, clk_code};
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset outputs: af_dly, cop_rdy set; others clear
    chk("R1 cfg outputs", cfg_bits(), 8'b0000_1100);
    chk("R1 a20", {7'b0, a20}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        io_write(VECS[i].addr, VECS[i].data);
      end else begin
        io_read(VECS[i].addr, v);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R4 R5: outputs after table (speed 00, option 05)
    #1;
    chk("R4 speed outputs", {4'b0, af_dly, cop_rdy, clk_code}, 8'h00);
    chk("R5 option outputs", {4'b0, rdy_ext, fast_vid, mm_en, mm_fast}, 8'h05);

    io_write(16'h0022, 8'h8E);
    io_write(16'h0023, 8'h62);
    #1;
    chk("R4 speed outputs set", {4'b0, af_dly, cop_rdy, clk_code}, 8'h0E);

    // R8 gate sources
    @(negedge clk); kbc = 1'b1; #1;
    chk("R8 kbc term", {7'b0, a20}, 8'h01);
    kbc = 1'b0; ncm = 1'b1; #1;
    chk("R8 master term", {7'b0, a20}, 8'h01);
    ncm = 1'b0; #1;
    chk("R8 all low", {7'b0, a20}, 8'h00);

    // R9 port 92 write reaches gate at the write edge
    @(negedge clk);
    addr = 16'h0092; wdata = 8'h02; wr = 1'b1;
    #(CLK_PERIOD/4);
    chk("R9 before edge", {7'b0, a20}, 8'h00);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R9 after edge", {7'b0, a20}, 8'h01);
    @(negedge clk); wr = 1'b0;
    io_write(16'h0092, 8'hFD);
    #1;
    chk("R9 cleared", {7'b0, a20}, 8'h00);

    // R1 reset in mid-run
    io_write(16'h0022, 8'h8F);
    io_write(16'h0023, 8'h0F);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 mid-run reset outputs", cfg_bits(), 8'b0000_1100);
    @(negedge clk); rst_n = 1'b1;
    io_read(16'h0022, v);
    chk("R1 index after reset", v, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule